// File: doc/BRIEF.md
# TLB Management Register Front End

This block is the set of control registers that privileged software uses to maintain a translation lookaside buffer. It holds a process-tag register, a 32-bit zone-protection word and an index register. It also provides three ports into the buffer: an entry-low window and an entry-high window, which reach the entry chosen by the index register, and a search window. The two halves of every entry are stored in the block's own memories. A per-entry tag ID is stored next to them. It is taken from the process-tag register when the high half is written, and it is copied back into that register when the high half is read.

A write to the search window sends a lookup out through a translator port. The translator answers in the same cycle. On a hit, the index register takes the matching entry number. On a miss, the top bit of the index register is set. Two configuration inputs decide whether the register set exists at all and which accesses are allowed. An access that is not allowed has no effect, returns zero on a read, and pulses an error output. Changing the process tag or the zone word pulses a flush request for downstream translation caches.

Top module: `tlb_sreg_frontend`

## Requirements
- R1: After reset the process-tag, zone and index registers read as 0, and rd_valid, acc_err and flush_req are low.
- R2: Register addresses are 0 process tag, 1 zone, 2 index, 3 search, 4 entry-low, 5 entry-high. Entry-low and entry-high writes store into the entry selected by index bits [IDX_W-1:0] (bits [5:0] at the default 64 entries). A read returns the stored word on rd_data with rd_valid high in the cycle after the read strobe.
- R3: An entry-high write records the entry's tag ID from the low 8 bits of the process-tag register. An entry-low write leaves the tag ID unchanged.
- R4: An allowed entry-high read loads the process-tag register with that entry's tag ID, zero-extended. No flush request is raised.
- R5: An allowed search write drives lu_req high in the same cycle, with lu_vpn equal to the written value with bits [9:0] cleared and lu_user equal to user_mode.
- R6: On a search hit the index register becomes lu_idx, zero-extended. On a miss, index bit 31 is set and its other bits keep their values.
- R7: With cfg_mode below 2, or with cfg_access equal to 0, every read returns 0, every write has no effect, and acc_err pulses in the cycle after the strobe.
- R8: Reads of the process-tag, zone, entry-low and entry-high registers need cfg_access bit 0. Without it the read returns 0 and acc_err pulses. Index reads need no rights beyond R7.
- R9: Writes to the process-tag, zone and search registers need cfg_access above 1. Otherwise the write is dropped, lu_req stays low and acc_err pulses. Index and entry writes need no rights beyond R7.
- R10: flush_req pulses in the cycle after an allowed process-tag or zone write whose value differs from the register's content. Writing the same value raises no flush.
- R11: Addresses 6 and 7 read as 0 without error. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Translation configuration; 2 or 3 means full mode |
| cfg_access | input | 2 | Access level: bit 0 grants reads, a value above 1 grants privileged writes |
| user_mode | input | 1 | Current privilege is user |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_wdata | input | DATA_W | Write value |
| rd_data | output | DATA_W | Read value, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| acc_err | output | 1 | Disallowed access pulse |
| flush_req | output | 1 | Downstream flush request pulse |
| lu_req | output | 1 | Lookup request to the translator |
| lu_vpn | output | DATA_W | Lookup address, page-number bits only |
| lu_user | output | 1 | Lookup performed in user mode |
| lu_hit | input | 1 | Translator reports a hit (same cycle) |
| lu_idx | input | IDX_W | Index of the hitting entry |

## Verification
The bench reads back entry-high words written under different process tags and then reads the process-tag register. A design that fails to capture the tag ID, or fails to move it back, leaves a stale tag. It drives a search miss after a hit with a non-zero index. A design that clears the index on a miss, instead of only raising bit 31, loses the low bits. It repeats a process-tag write with an unchanged value to catch a flush raised on every write. It also steps through each access level and disables the block, to catch a denied access that still changes state or returns live data.

// File: rtl/tlb_sreg_pkg.sv
package tlb_sreg_pkg;
  typedef enum logic [2:0] {
    RA_PID    = 3'd0,
    RA_ZONE   = 3'd1,
    RA_INDEX  = 3'd2,
    RA_SEARCH = 3'd3,
    RA_ENT_LO = 3'd4,
    RA_ENT_HI = 3'd5,
    RA_RSV6   = 3'd6,
    RA_RSV7   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/tlb_sreg_access.sv
module tlb_sreg_access
  import tlb_sreg_pkg::*;
(
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_access,
  input  logic [2:0] reg_addr,
  input  logic       reg_rd,
  input  logic       reg_wr,
  output logic       rd_go,
  output logic       wr_go,
  output logic       fault
);
  reg_addr_e ra;
  logic      enabled;
  logic      rd_needs_view;
  logic      wr_needs_priv;

  assign ra      = reg_addr_e'(reg_addr);
  assign enabled = (cfg_mode >= 2'd2) && (cfg_access != 2'd0);

  always_comb begin
    rd_needs_view = (ra == RA_PID) || (ra == RA_ZONE) ||
                    (ra == RA_ENT_LO) || (ra == RA_ENT_HI);
    wr_needs_priv = (ra == RA_PID) || (ra == RA_ZONE) || (ra == RA_SEARCH);
  end

  assign rd_go = reg_rd && enabled && (!rd_needs_view || cfg_access[0]);
  assign wr_go = reg_wr && enabled && (!wr_needs_priv || (cfg_access > 2'd1));
  assign fault = (reg_rd && !rd_go) || (reg_wr && !wr_go);
endmodule

// File: rtl/tlb_word_ram.sv
module tlb_word_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/tlb_sreg_frontend.sv
module tlb_sreg_frontend
  import tlb_sreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ENTRIES  = 64,
  parameter int TID_W    = 8,
  parameter int PAGE_LSB = 10,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_access,
  input  logic              user_mode,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              acc_err,
  output logic              flush_req,
  output logic              lu_req,
  output logic [DATA_W-1:0] lu_vpn,
  output logic              lu_user,
  input  logic              lu_hit,
  input  logic [IDX_W-1:0]  lu_idx
);
  localparam int MISS_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] PAGE_MASK =
    {{(DATA_W-PAGE_LSB){1'b1}}, {PAGE_LSB{1'b0}}};

  logic      rd_go, wr_go, fault;
  reg_addr_e ra;
  logic      is_entry;

  tlb_sreg_access u_acc (
    .cfg_mode  (cfg_mode),
    .cfg_access(cfg_access),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .fault     (fault)
  );

  assign ra       = reg_addr_e'(reg_addr);
  assign is_entry = (ra == RA_ENT_LO) || (ra == RA_ENT_HI);

  logic [DATA_W-1:0] pid_q, zone_q, index_q, snap_q;
  reg_addr_e         rd_sel_q;
  logic [IDX_W-1:0]  ent_sel;
  assign ent_sel = index_q[IDX_W-1:0];

  // Tag IDs: small side array, read combinationally so that a high-word
  // read can load the process-tag register on the strobe edge.
  logic [TID_W-1:0] tid_mem [ENTRIES];
  logic [TID_W-1:0] tid_rd;
  assign tid_rd = tid_mem[ent_sel];

  // Bank 0 holds the low (data) words, bank 1 the high (tag) words.
  logic [1:0]        bank_we;
  logic [DATA_W-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_we[b] = wr_go && is_entry && (reg_addr[0] == b[0]);
    tlb_word_ram #(.DEPTH(ENTRIES), .WIDTH(DATA_W)) u_ram (
      .clk  (clk),
      .we   (bank_we[b]),
      .re   (rd_go && is_entry && (reg_addr[0] == b[0])),
      .addr (ent_sel),
      .wdata(reg_wdata),
      .rdata(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (bank_we[1]) tid_mem[ent_sel] <= pid_q[TID_W-1:0];
  end

  // Lookup port
  assign lu_req  = wr_go && (ra == RA_SEARCH);
  assign lu_vpn  = reg_wdata & PAGE_MASK;
  assign lu_user = user_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      pid_q     <= '0;
      zone_q    <= '0;
      index_q   <= '0;
      snap_q    <= '0;
      rd_sel_q  <= RA_RSV6;
      rd_valid  <= 1'b0;
      acc_err   <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      rd_valid  <= reg_rd;
      acc_err   <= fault;
      flush_req <= 1'b0;
      if (wr_go) begin
        unique case (ra)
          RA_PID: if (reg_wdata != pid_q) begin
            pid_q     <= reg_wdata;
            flush_req <= 1'b1;
          end
          RA_ZONE: if (reg_wdata != zone_q) begin
            zone_q    <= reg_wdata;
            flush_req <= 1'b1;
          end
          RA_INDEX: index_q <= reg_wdata;
          RA_SEARCH: begin
            if (lu_hit) index_q <= DATA_W'(lu_idx);
            else        index_q[MISS_BIT] <= 1'b1;
          end
          default: ;
        endcase
      end
      if (reg_rd) begin
        rd_sel_q <= rd_go ? ra : RA_RSV6;
        unique case (ra)
          RA_PID:   snap_q <= rd_go ? pid_q : '0;
          RA_ZONE:  snap_q <= rd_go ? zone_q : '0;
          RA_INDEX: snap_q <= rd_go ? index_q : '0;
          default:  snap_q <= '0;
        endcase
        if (rd_go && (ra == RA_ENT_HI)) pid_q <= DATA_W'(tid_rd);
      end
    end
  end

  always_comb begin
    unique case (rd_sel_q)
      RA_ENT_LO: rd_data = bank_q[0];
      RA_ENT_HI: rd_data = bank_q[1];
      default:   rd_data = snap_q;
    endcase
  end
endmodule

// File: rtl/tlb_sreg_checker.sv
module tlb_sreg_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_mode,
  input logic [1:0]        cfg_access,
  input logic              user_mode,
  input logic [2:0]        reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              acc_err,
  input logic              flush_req,
  input logic              lu_req,
  input logic              lu_user,
  input logic              lu_hit,
  input logic [IDX_W-1:0]  lu_idx,
  input logic [DATA_W-1:0] index_q
);
  logic en;
  assign en = (cfg_mode >= 2'd2) && (cfg_access != 2'd0);

  assert_rd_valid_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(reg_rd));

  assert_lookup_from_search_R5: assert property (@(posedge clk) disable iff (rst)
    lu_req |-> (reg_wr && reg_addr == 3'd3 && lu_user == user_mode));

  assert_miss_sets_top_R6: assert property (@(posedge clk) disable iff (rst)
    (lu_req && !lu_hit) |=> index_q[DATA_W-1]);

  assert_hit_loads_index_R6: assert property (@(posedge clk) disable iff (rst)
    (lu_req && lu_hit) |=> index_q == DATA_W'($past(lu_idx)));

  assert_disabled_faults_R7: assert property (@(posedge clk) disable iff (rst)
    ((reg_rd || reg_wr) && !en) |=> (acc_err && !flush_req));

  assert_view_denied_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && en && !cfg_access[0] &&
     (reg_addr == 3'd0 || reg_addr == 3'd1 || reg_addr == 3'd4 || reg_addr == 3'd5))
    |=> (acc_err && rd_data == '0));

  assert_priv_write_denied_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && en && cfg_access < 2'd2 && reg_addr <= 3'd3 && reg_addr != 3'd2)
    |-> !lu_req);

  assert_flush_source_R10: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> ($past(reg_wr) && $past(reg_addr) <= 3'd1 && !acc_err));
endmodule

bind tlb_sreg_frontend tlb_sreg_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_mode  (cfg_mode),
  .cfg_access(cfg_access),
  .user_mode (user_mode),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .acc_err   (acc_err),
  .flush_req (flush_req),
  .lu_req    (lu_req),
  .lu_user   (lu_user),
  .lu_hit    (lu_hit),
  .lu_idx    (lu_idx),
  .index_q   (index_q)
);

// File: tb/tlb_sreg_frontend_bench.sv
module tlb_sreg_frontend_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'd3;
  logic [1:0]  cfg_access = 2'd3;
  logic        user_mode = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid, acc_err, flush_req, lu_req, lu_user;
  logic [31:0] lu_vpn;
  logic        lu_hit = 1'b0;
  logic [5:0]  lu_idx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_sreg_frontend u_tlb_sreg_frontend (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_access(cfg_access),
    .user_mode(user_mode), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .acc_err(acc_err), .flush_req(flush_req), .lu_req(lu_req), .lu_vpn(lu_vpn),
    .lu_user(lu_user), .lu_hit(lu_hit), .lu_idx(lu_idx)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  logic [31:0] m_pid = '0, m_zone = '0, m_index = '0;
  logic [31:0] m_lo [64];
  logic [31:0] m_hi [64];
  logic [7:0]  m_tid [64];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge after comparing.
  task automatic op(input bit is_wr, input logic [2:0] a, input logic [31:0] v,
                    input bit hit, input logic [5:0] hidx, input string req);
    bit en, go, exp_flush, exp_lu;
    logic [31:0] exp_data;
    int e;
    en = (cfg_mode >= 2) && (cfg_access != 0);
    e  = int'(m_index[5:0]);
    exp_flush = 0; exp_lu = 0; exp_data = '0;
    reg_addr = a; reg_wdata = v; lu_hit = hit; lu_idx = hidx;
    reg_wr = is_wr; reg_rd = !is_wr;
    if (is_wr) begin
      go = en && (((a == 0) || (a == 1) || (a == 3)) ? (cfg_access > 1) : 1'b1);
      if (go) begin
        case (a)
          3'd0: if (v != m_pid)  begin m_pid = v;  exp_flush = 1; end
          3'd1: if (v != m_zone) begin m_zone = v; exp_flush = 1; end
          3'd2: m_index = v;
          3'd3: begin exp_lu = 1; if (hit) m_index = {26'd0, hidx}; else m_index[31] = 1'b1; end
          3'd4: m_lo[e] = v;
          3'd5: begin m_hi[e] = v; m_tid[e] = m_pid[7:0]; end
          default: ;
        endcase
      end
    end else begin
      go = en && (((a == 0) || (a == 1) || (a == 4) || (a == 5)) ? cfg_access[0] : 1'b1);
      if (go) begin
        case (a)
          3'd0: exp_data = m_pid;
          3'd1: exp_data = m_zone;
          3'd2: exp_data = m_index;
          3'd4: exp_data = m_lo[e];
          3'd5: begin exp_data = m_hi[e]; m_pid = {24'd0, m_tid[e]}; end
          default: exp_data = '0;
        endcase
      end
    end
    #1;
    chk({req, " lu_req"}, {31'd0, lu_req}, {31'd0, exp_lu});
    if (exp_lu) begin
      chk({req, " lu_vpn"}, lu_vpn, v & 32'hFFFF_FC00);
      chk({req, " lu_user"}, {31'd0, lu_user}, {31'd0, user_mode});
    end
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    chk({req, " acc_err"}, {31'd0, acc_err}, {31'd0, !go});
    chk({req, " flush_req"}, {31'd0, flush_req}, {31'd0, exp_flush});
    chk({req, " rd_valid"}, {31'd0, rd_valid}, {31'd0, !is_wr});
    if (!is_wr) chk({req, " rd_data"}, rd_data, exp_data);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v, input string req);
    op(1'b1, a, v, 1'b0, 6'd0, req);
  endtask
  task automatic rd(input logic [2:0] a, input string req);
    op(1'b0, a, '0, 1'b0, 6'd0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 acc_err", {31'd0, acc_err}, 32'd0);
    chk("R1 flush_req", {31'd0, flush_req}, 32'd0);
    rd(3'd0, "R1 pid"); rd(3'd1, "R1 zone"); rd(3'd2, "R1 index");
    // R10 flush on change only
    wr(3'd0, 32'h0000_005A, "R10 pid change");
    wr(3'd0, 32'h0000_005A, "R10 pid same");
    wr(3'd1, 32'hDEAD_BEEF, "R10 zone change");
    wr(3'd1, 32'hDEAD_BEEF, "R10 zone same");
    // R2 R3 entry writes
    wr(3'd2, 32'd3, "R2 index");
    wr(3'd5, 32'hAAAA_0040, "R3 hi write");
    wr(3'd4, 32'h0000_1234, "R2 lo write");
    wr(3'd2, 32'h0000_0107, "R2 index low bits");
    wr(3'd0, 32'h0000_0133, "R3 pid second");
    wr(3'd5, 32'hBBBB_0040, "R3 hi write 2");
    wr(3'd4, 32'h5555_6666, "R2 lo write 2");
    wr(3'd0, 32'h0000_0011, "R3 pid third");
    wr(3'd4, 32'h7777_8888, "R3 lo keeps tid");
    rd(3'd4, "R2 lo read");
    rd(3'd5, "R4 hi read");
    rd(3'd0, "R4 pid from tid");
    wr(3'd2, 32'd3, "R2 index back");
    rd(3'd5, "R2 hi read");
    rd(3'd4, "R2 lo read 3");
    rd(3'd0, "R4 pid from tid 2");
    // R5 R6 search
    op(1'b1, 3'd3, 32'h1234_5FFF, 1'b1, 6'd9, "R5 search hit");
    rd(3'd2, "R6 index after hit");
    op(1'b1, 3'd3, 32'hFFFF_FFFF, 1'b0, 6'd0, "R6 search miss");
    rd(3'd2, "R6 index after miss");
    user_mode = 1;
    op(1'b1, 3'd3, 32'h0000_0400, 1'b1, 6'd63, "R5 search user");
    rd(3'd2, "R6 index hit 63");
    user_mode = 0;
    // R9 write rights
    cfg_access = 2'd1;
    wr(3'd0, 32'h0000_00EE, "R9 pid denied");
    wr(3'd1, 32'h0, "R9 zone denied");
    op(1'b1, 3'd3, 32'h0000_1000, 1'b1, 6'd1, "R9 search denied");
    wr(3'd2, 32'd3, "R9 index allowed");
    wr(3'd4, 32'hCAFE_0001, "R9 lo allowed");
    rd(3'd0, "R9 pid unchanged");
    rd(3'd4, "R9 lo read");
    // R8 read rights
    cfg_access = 2'd2;
    rd(3'd0, "R8 pid denied");
    rd(3'd1, "R8 zone denied");
    rd(3'd5, "R8 hi denied");
    rd(3'd4, "R8 lo denied");
    rd(3'd2, "R8 index allowed");
    cfg_access = 2'd3;
    rd(3'd0, "R8 pid unchanged after denied hi");
    // R7 disabled
    cfg_mode = 2'd1;
    wr(3'd2, 32'd20, "R7 mode write");
    rd(3'd2, "R7 mode read");
    cfg_mode = 2'd3; cfg_access = 2'd0;
    wr(3'd1, 32'h1, "R7 access write");
    rd(3'd1, "R7 access read");
    cfg_access = 2'd3;
    rd(3'd2, "R7 index kept");
    rd(3'd1, "R7 zone kept");
    // R11 reserved
    wr(3'd7, 32'hFFFF_FFFF, "R11 write");
    rd(3'd6, "R11 read 6");
    rd(3'd7, "R11 read 7");
    rd(3'd2, "R11 index kept");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule